// File: doc/BRIEF.md
# Cartridge Memory Bank Controller

This block sits on the cartridge side of an 8-bit processor bus with a 16-bit address, separate read and write strobes and an 8-bit write data path. It watches bus writes into the lower half of the address map and treats them as updates to its control registers. Those registers are a RAM unlock byte, a ROM bank number, a RAM bank number and a banking-mode bit. It then turns bus addresses into wide physical addresses and chip selects for an external ROM and an external RAM.

A static two-bit input selects one of three controller variants. The variants differ in how wide the ROM bank number is, in how a bank write is split across the address range, and in whether a written bank of zero is replaced by bank one.

In the five-bit variant, the mode bit also decides whether the upper control range extends the ROM bank number or selects a RAM bank. Strobes are level-sensitive. A register write takes effect at the clock edge during which the write strobe is high. The address outputs and chip selects follow the bus combinationally, so the memories can be treated as asynchronous devices.

Top module: `cart_bank_mapper`

## Requirements
- R1: After synchronous reset the ROM bank is 1, the RAM bank is 0, the mode bit is 0 and the RAM unlock byte is 0x00, so RAM is locked.
- R2: A write anywhere in 0x0000–0x1FFF loads the full data byte into the unlock register. `ram_cs` is high only when that byte equals 0x0A, the address lies in 0xA000–0xBFFF, and a read or write strobe is high.
- R3: `ctrl_kind` encodings are 0 = five-bit variant, 1 = seven-bit variant, 2 or 3 = nine-bit variant. In the five-bit variant, a write in 0x2000–0x3FFF sets ROM bank bits 4:0 from data[4:0] and leaves bits 8:5 unchanged. If data[4:0] is zero, bank bits 4:0 become 1.
- R4: In the seven-bit variant, a write in 0x2000–0x3FFF sets the ROM bank to data[6:0] and clears bits 8:7. If data[6:0] is zero, the bank becomes 1.
- R5: In the nine-bit variant, a write in 0x2000–0x2FFF sets ROM bank bits 7:0 from the data byte, and a write in 0x3000–0x3FFF sets bank bit 8 from data[0]. Bank 0 is kept as written.
- R6: A write in 0x4000–0x5FFF sets ROM bank bits 6:5 from data[1:0] when the variant is five-bit and the mode is 0. In every other case it sets the RAM bank from data[3:0].
- R7: A write in 0x6000–0x7FFF sets the mode bit from data[0].
- R8: A read below 0x4000 asserts `rom_cs` and drives `rom_addr` equal to the bus address, with no banking.
- R9: A read in 0x4000–0x7FFF asserts `rom_cs` and drives `rom_addr` = ROM bank × 0x4000 + (address − 0x4000).
- R10: In the RAM window, `ram_addr` = RAM bank × 0x2000 + (address − 0xA000). In the five-bit variant with mode 0, bank 0 is used whatever the RAM bank register holds.
- R11: `rom_cs` is high only for a read strobe at an address below 0x8000. Writes in the ROM range never select the ROM.
- R12: There is no edge detection on the strobes. A write strobe held high over several clock edges reloads the register at each edge, so the data present at the last edge is the value kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_kind | input | 2 | Static controller variant select |
| cpu_addr | input | 16 | Bus address |
| cpu_wr | input | 1 | Write strobe, level-sensitive |
| cpu_rd | input | 1 | Read strobe, level-sensitive |
| cpu_wdata | input | 8 | Write data |
| rom_cs | output | 1 | ROM chip select |
| rom_addr | output | 23 | Physical ROM byte address |
| ram_cs | output | 1 | RAM chip select |
| ram_addr | output | 17 | Physical RAM byte address |

## Verification
The unlock register is swept through all 256 values, which confirms that exactly one byte opens the RAM window. Each variant's ROM bank write is driven with all 256 data bytes. For each byte the bench reads back the banked ROM address, which separates masking of the data bits from zero-bank substitution. In the nine-bit variant this is repeated for both values of the top bank bit. The RAM bank is swept in the modes where it applies and in the mode where it must be ignored. Reads and writes outside the ROM range, together with a write strobe held over two edges with changing data, separate a gated, level-sensitive decoder from one that detects edges.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

    localparam int CPU_AW      = 16;
    localparam int DATA_W      = 8;
    localparam int ROM_BANK_W  = 9;
    localparam int RAM_BANK_W  = 4;
    localparam int ROM_PAGE_W  = 14;
    localparam int RAM_PAGE_W  = 13;
    localparam int ROM_AW      = ROM_BANK_W + ROM_PAGE_W;
    localparam int RAM_AW      = RAM_BANK_W + RAM_PAGE_W;
    localparam int FIVE_W      = 5;
    localparam int SEVEN_W     = 7;
    localparam logic [DATA_W-1:0] RAM_KEY = 8'h0A;

    typedef enum logic [1:0] {
        KIND_FIVE  = 2'd0,
        KIND_SEVEN = 2'd1,
        KIND_NINE  = 2'd2,
        KIND_NINE2 = 2'd3
    } kind_e;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_UNLOCK,
        TGT_BANK_LO,
        TGT_BANK_TOP,
        TGT_UPPER,
        TGT_MODE
    } wtarget_e;

    typedef struct packed {
        logic [DATA_W-1:0]     ram_key;
        logic [ROM_BANK_W-1:0] rom_bank;
        logic [RAM_BANK_W-1:0] ram_bank;
        logic                  mode;
    } bank_state_t;

    function automatic wtarget_e decode_write(input logic [3:0] nib);
        case (nib)
            4'h0, 4'h1: return TGT_UNLOCK;
            4'h2:       return TGT_BANK_LO;
            4'h3:       return TGT_BANK_TOP;
            4'h4, 4'h5: return TGT_UPPER;
            4'h6, 4'h7: return TGT_MODE;
            default:    return TGT_NONE;
        endcase
    endfunction

    function automatic logic in_ram_window(input logic [2:0] top3);
        return top3 == 3'b101;
    endfunction

    function automatic logic is_nine(input kind_e k);
        return (k == KIND_NINE) || (k == KIND_NINE2);
    endfunction

endpackage

// File: rtl/cbm_regs.sv
module cbm_regs
    import cbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  kind_e             kind,
    input  logic              wr,
    input  logic [3:0]        addr_nib,
    input  logic [DATA_W-1:0] wdata,
    output bank_state_t       state_q
);

    bank_state_t state_d;
    wtarget_e    tgt;
    logic        five_low_mode;

    assign tgt           = decode_write(addr_nib);
    assign five_low_mode = (kind == KIND_FIVE) && !state_q.mode;

    always_comb begin
        state_d = state_q;
        if (wr) begin
            case (tgt)
                TGT_UNLOCK: state_d.ram_key = wdata;
                TGT_BANK_LO, TGT_BANK_TOP: begin
                    if (kind == KIND_FIVE) begin
                        if (wdata[FIVE_W-1:0] == '0)
                            state_d.rom_bank[FIVE_W-1:0] = FIVE_W'(1);
                        else
                            state_d.rom_bank[FIVE_W-1:0] = wdata[FIVE_W-1:0];
                    end else if (kind == KIND_SEVEN) begin
                        state_d.rom_bank = '0;
                        if (wdata[SEVEN_W-1:0] == '0)
                            state_d.rom_bank[SEVEN_W-1:0] = SEVEN_W'(1);
                        else
                            state_d.rom_bank[SEVEN_W-1:0] = wdata[SEVEN_W-1:0];
                    end else if (tgt == TGT_BANK_LO) begin
                        state_d.rom_bank[DATA_W-1:0] = wdata;
                    end else begin
                        state_d.rom_bank[ROM_BANK_W-1] = wdata[0];
                    end
                end
                TGT_UPPER: begin
                    if (five_low_mode)
                        state_d.rom_bank[FIVE_W+1:FIVE_W] = wdata[1:0];
                    else
                        state_d.ram_bank = wdata[RAM_BANK_W-1:0];
                end
                TGT_MODE: state_d.mode = wdata[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.ram_key  <= '0;
            state_q.rom_bank <= ROM_BANK_W'(1);
            state_q.ram_bank <= '0;
            state_q.mode     <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/cbm_rom_map.sv
module cbm_rom_map
    import cbm_pkg::*;
(
    input  logic [CPU_AW-1:0]     addr,
    input  logic                  rd,
    input  logic [ROM_BANK_W-1:0] rom_bank,
    output logic                  rom_cs,
    output logic [ROM_AW-1:0]     rom_addr
);

    logic                  upper_page;
    logic [ROM_BANK_W-1:0] page_bank;

    assign upper_page = addr[ROM_PAGE_W];
    assign page_bank  = upper_page ? rom_bank : '0;
    assign rom_cs     = rd && !addr[CPU_AW-1];
    assign rom_addr   = {page_bank, addr[ROM_PAGE_W-1:0]};

endmodule

// File: rtl/cbm_ram_map.sv
module cbm_ram_map
    import cbm_pkg::*;
(
    input  kind_e             kind,
    input  logic [CPU_AW-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  bank_state_t       state,
    output logic              ram_cs,
    output logic [RAM_AW-1:0] ram_addr
);

    logic                  unlocked;
    logic                  hit;
    logic [RAM_BANK_W-1:0] eff_bank;

    assign unlocked = state.ram_key == RAM_KEY;
    assign hit      = in_ram_window(addr[CPU_AW-1:CPU_AW-3]);
    assign eff_bank = ((kind == KIND_FIVE) && !state.mode) ? '0 : state.ram_bank;
    assign ram_cs   = unlocked && hit && (rd || wr);
    assign ram_addr = {eff_bank, addr[RAM_PAGE_W-1:0]};

endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
    import cbm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [1:0]            ctrl_kind,
    input  logic [CPU_AW-1:0]     cpu_addr,
    input  logic                  cpu_wr,
    input  logic                  cpu_rd,
    input  logic [DATA_W-1:0]     cpu_wdata,
    output logic                  rom_cs,
    output logic [ROM_AW-1:0]     rom_addr,
    output logic                  ram_cs,
    output logic [RAM_AW-1:0]     ram_addr
);

    kind_e       kind;
    bank_state_t bank_q;

    assign kind = kind_e'(ctrl_kind);

    cbm_regs i_regs (
        .clk      (clk),
        .rst      (rst),
        .kind     (kind),
        .wr       (cpu_wr),
        .addr_nib (cpu_addr[CPU_AW-1:CPU_AW-4]),
        .wdata    (cpu_wdata),
        .state_q  (bank_q)
    );

    cbm_rom_map i_rom (
        .addr     (cpu_addr),
        .rd       (cpu_rd),
        .rom_bank (bank_q.rom_bank),
        .rom_cs   (rom_cs),
        .rom_addr (rom_addr)
    );

    cbm_ram_map i_ram (
        .kind     (kind),
        .addr     (cpu_addr),
        .rd       (cpu_rd),
        .wr       (cpu_wr),
        .state    (bank_q),
        .ram_cs   (ram_cs),
        .ram_addr (ram_addr)
    );

endmodule

// File: rtl/cbm_checker.sv
module cbm_checker
    import cbm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [1:0]        ctrl_kind,
    input logic [CPU_AW-1:0] cpu_addr,
    input logic              cpu_wr,
    input logic              cpu_rd,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic              rom_cs,
    input logic [ROM_AW-1:0] rom_addr,
    input logic              ram_cs,
    input logic [RAM_AW-1:0] ram_addr,
    input bank_state_t       bank_q
);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (bank_q.rom_bank == ROM_BANK_W'(1)) && (bank_q.ram_bank == '0)
                && !bank_q.mode && (bank_q.ram_key != RAM_KEY));

    assert_ram_gate_R2: assert property (@(posedge clk) disable iff (rst)
        ram_cs |-> (bank_q.ram_key == RAM_KEY) && (cpu_addr[15:13] == 3'b101)
                   && (cpu_rd || cpu_wr));

    assert_five_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
        (ctrl_kind == 2'd0) && cpu_wr && (cpu_addr[15:13] == 3'b001)
        |=> bank_q.rom_bank[4:0] != 5'd0);

    assert_seven_bank_R4: assert property (@(posedge clk) disable iff (rst)
        (ctrl_kind == 2'd1) && cpu_wr && (cpu_addr[15:13] == 3'b001)
        |=> (bank_q.rom_bank[8:7] == 2'd0) && (bank_q.rom_bank[6:0] != 7'd0));

    assert_mode_load_R7: assert property (@(posedge clk) disable iff (rst)
        cpu_wr && (cpu_addr[15:13] == 3'b011) |=> bank_q.mode == $past(cpu_wdata[0]));

    assert_low_rom_R8: assert property (@(posedge clk) disable iff (rst)
        cpu_rd && (cpu_addr[15:14] == 2'b00)
        |-> rom_cs && (rom_addr == ROM_AW'(cpu_addr)));

    assert_banked_rom_R9: assert property (@(posedge clk) disable iff (rst)
        rom_cs && cpu_addr[14]
        |-> (rom_addr[ROM_AW-1:ROM_PAGE_W] == bank_q.rom_bank)
            && (rom_addr[ROM_PAGE_W-1:0] == cpu_addr[13:0]));

    assert_ram_fixed_R10: assert property (@(posedge clk) disable iff (rst)
        (ctrl_kind == 2'd0) && !bank_q.mode && ram_cs
        |-> ram_addr[RAM_AW-1:RAM_PAGE_W] == '0);

    assert_rom_select_R11: assert property (@(posedge clk) disable iff (rst)
        rom_cs |-> cpu_rd && !cpu_addr[15]);

endmodule

bind cart_bank_mapper cbm_checker i_checker (
    .clk       (clk),
    .rst       (rst),
    .ctrl_kind (ctrl_kind),
    .cpu_addr  (cpu_addr),
    .cpu_wr    (cpu_wr),
    .cpu_rd    (cpu_rd),
    .cpu_wdata (cpu_wdata),
    .rom_cs    (rom_cs),
    .rom_addr  (rom_addr),
    .ram_cs    (ram_cs),
    .ram_addr  (ram_addr),
    .bank_q    (bank_q)
);

// File: tb/test_cart_bank_mapper.sv
module test_cart_bank_mapper;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  kind = 2'd0;
    logic [15:0] addr = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [7:0]  wdata = '0;
    logic        rom_cs;
    logic [22:0] rom_addr;
    logic        ram_cs;
    logic [16:0] ram_addr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cart_bank_mapper i_cart_bank_mapper (
        .clk       (clk),
        .rst       (rst),
        .ctrl_kind (kind),
        .cpu_addr  (addr),
        .cpu_wr    (wr),
        .cpu_rd    (rd),
        .cpu_wdata (wdata),
        .rom_cs    (rom_cs),
        .rom_addr  (rom_addr),
        .ram_cs    (ram_cs),
        .ram_addr  (ram_addr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] k);
        @(negedge clk);
        kind = k; rst = 1'b1; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic poke(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        rd = 1'b0; addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic peek(input logic [15:0] a);
        @(negedge clk);
        wr = 1'b0; addr = a; rd = 1'b1;
        #(CLK_PERIOD/4);
    endtask

    function automatic logic [31:0] rom_exp(input int bank, input logic [15:0] a);
        return bank * 32'h4000 + (32'(a) - 32'h4000);
    endfunction

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset(2'd1);
        peek(16'h4000);
        chk("R1 rom bank after reset", rom_addr, 32'h4000);
        chk("R1 rom_cs after reset", rom_cs, 1);
        peek(16'hA000);
        chk("R1 ram locked after reset", ram_cs, 0);
        poke(16'h0000, 8'h0A);
        peek(16'hB000);
        chk("R1 ram bank 0 after reset", ram_addr, 32'h1000);

        // R2: unlock byte sweep
        for (int e = 0; e < 256; e++) begin
            poke(16'h1FFF, 8'(e));
            peek(16'hA123);
            chk("R2 unlock sweep", ram_cs, (e == 8'h0A) ? 1 : 0);
        end
        poke(16'h0100, 8'h0A);
        peek(16'hC000);
        chk("R2 no select outside window", ram_cs, 0);
        @(negedge clk);
        rd = 1'b0; addr = 16'hBFFF; wdata = 8'h55; wr = 1'b1;
        #(CLK_PERIOD/4);
        chk("R2 ram_cs on write", ram_cs, 1);
        chk("R11 rom_cs low on ram write", rom_cs, 0);
        @(negedge clk);
        wr = 1'b0;
        #(CLK_PERIOD/4);
        chk("R2 no strobe no select", ram_cs, 0);

        // R8 and R11
        for (int a = 0; a < 16'h4000; a += 16'h0123) begin
            peek(16'(a));
            chk("R8 low rom address", rom_addr, 32'(a));
            chk("R8 low rom select", rom_cs, 1);
        end
        peek(16'h8000);
        chk("R11 no rom select at 0x8000", rom_cs, 0);
        peek(16'hFFFF);
        chk("R11 no rom select at 0xFFFF", rom_cs, 0);
        @(negedge clk);
        rd = 1'b0; addr = 16'h2000; wdata = 8'h04; wr = 1'b1;
        #(CLK_PERIOD/4);
        chk("R11 rom write never selects", rom_cs, 0);
        @(negedge clk);
        wr = 1'b0;

        // R4: seven-bit sweep
        for (int v = 0; v < 256; v++) begin
            poke(16'h2000 + 16'(v), 8'(v));
            peek(16'h4155);
            chk("R4 seven-bit bank", rom_addr,
                rom_exp((v[6:0] == 0) ? 1 : v[6:0], 16'h4155));
        end
        // R6 / R10: ram bank sweep in seven-bit variant
        for (int b = 0; b < 16; b++) begin
            poke(16'h5000, 8'(b) | 8'hF0);
            peek(16'hA456);
            chk("R10 ram bank sweep", ram_addr, b * 32'h2000 + 32'h456);
        end

        // R3: five-bit variant
        do_reset(2'd0);
        for (int v = 0; v < 256; v++) begin
            poke(16'h3F00, 8'(v));
            peek(16'h7ABC);
            chk("R3 five-bit bank", rom_addr,
                rom_exp((v[4:0] == 0) ? 1 : v[4:0], 16'h7ABC));
        end
        poke(16'h0000, 8'h0A);
        poke(16'h4000, 8'hFE);
        poke(16'h2000, 8'h03);
        peek(16'h7FFF);
        chk("R6 five-bit upper bits", rom_addr, rom_exp(32'h43, 16'h7FFF));
        poke(16'h2000, 8'h00);
        peek(16'h4000);
        chk("R3 upper bits kept on zero", rom_addr, rom_exp(32'h41, 16'h4000));
        peek(16'hA456);
        chk("R10 mode 0 forces ram bank 0", ram_addr, 32'h456);
        poke(16'h6000, 8'h01);
        poke(16'h4000, 8'h05);
        peek(16'hA456);
        chk("R7 mode 1 ram bank", ram_addr, 5 * 32'h2000 + 32'h456);
        peek(16'h4000);
        chk("R6 mode 1 leaves rom bank", rom_addr, rom_exp(32'h41, 16'h4000));
        poke(16'h7FFF, 8'hFE);
        peek(16'hA456);
        chk("R7 mode 0 from data bit 0", ram_addr, 32'h456);

        // R5: nine-bit variant
        do_reset(2'd2);
        for (int hi = 0; hi < 2; hi++) begin
            poke(16'h3ABC, (hi != 0) ? 8'hFF : 8'hFE);
            for (int lo = 0; lo < 256; lo++) begin
                poke(16'h2ABC, 8'(lo));
                peek(16'h5000);
                chk("R5 nine-bit bank", rom_addr, rom_exp(hi * 256 + lo, 16'h5000));
            end
        end
        poke(16'h4000, 8'h07);
        poke(16'h0000, 8'h0A);
        peek(16'hA010);
        chk("R6 nine-bit ram bank", ram_addr, 7 * 32'h2000 + 32'h10);

        // R12: level-sensitive strobe
        @(negedge clk);
        rd = 1'b0; addr = 16'h2000; wdata = 8'h03; wr = 1'b1;
        @(negedge clk);
        wdata = 8'h09;
        @(negedge clk);
        wr = 1'b0;
        peek(16'h4000);
        chk("R12 held strobe keeps last data", rom_addr, rom_exp(256 + 9, 16'h4000));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule